// File: doc/BRIEF.md
# ADC Result Offset Correction and Formatting Stage

This stage sits between a successive-approximation converter and its result register. Each accepted beat carries a raw conversion code, a 2-bit resolution selector, a single-ended/differential flag and the current offset-correction word. The stage works out the active resolution N from the selector and the flag. It reads the low N bits of the raw code, removes the offset and clips the difference to the range that resolution can represent. It then presents the value as a 16-bit word. Single-ended results are padded with zeros. Differential results are padded with copies of their sign bit.

The data path is a single registered stage with a valid/ready handshake on each side. A beat is taken on a rising edge where `in_valid` and `in_ready` are both high. The result is held in `out_data` with `out_valid` high until a rising edge sees `out_ready` high. While a result is waiting and `out_ready` is low, `in_ready` is low and the stage takes nothing new. When `out_ready` is high, a new beat can replace the held one on the same edge, so the stage sustains one beat per cycle. The offset word is treated as a plain control value and is sampled together with the beat.

Top module: `adc_result_corrector`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: The resolution N is set by `in_mode` and `in_diff` as follows:
  - mode 0 gives N=8 for single-ended and 9 for differential;
  - mode 1 gives 12 and 13;
  - mode 2 gives 10 and 11;
  - mode 3 gives 16 for both.
- R3: Only bits N-1..0 of `in_raw` are used, and bits above them have no effect. The field is read as unsigned when `in_diff`=0 and as two's complement when `in_diff`=1.
- R4: The corrected value is the raw field minus `in_offset`. The offset is a 16-bit two's-complement number, and the subtraction is exact, with no wrap.
- R5: A corrected value above the mode maximum is replaced by that maximum. The maximum is 2^N-1 for single-ended and 2^(N-1)-1 for differential.
- R6: A corrected value below the mode minimum is replaced by that minimum. The minimum is 0 for single-ended and -2^(N-1) for differential.
- R7: Bits 15..N of `out_data` are 0 for single-ended results and equal to bit N-1 for differential results.
- R8: A beat accepted on a rising edge appears on `out_data`, with `out_valid` high, right after that edge: one cycle of latency. `out_valid` falls after an edge that sees `out_ready` high with no new beat accepted.
- R9: While `out_valid` is high and `out_ready` is low:
  - `out_data` and `out_valid` hold their values;
  - `in_ready` is low;
  - an offered beat is not taken until `out_ready` returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Stage can take a beat this cycle |
| in_raw | input | 16 | Raw conversion code |
| in_mode | input | 2 | Resolution selector |
| in_diff | input | 1 | 1 = differential conversion |
| in_offset | input | 16 | Two's-complement offset to subtract |
| out_valid | output | 1 | Result held on out_data |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 16 | Corrected, clipped and padded result |

## Verification
The bench builds the stage with its default parameters: a 16-bit data word and an 18-bit internal difference. The full-width mode can therefore be driven to its extremes. A raw value of 65535 with an offset of -1, or a differential value of -32768 with an offset of +1, falls outside 16 bits and must clip rather than wrap. The same defaults expose the narrow modes to raw codes with the upper bits set, which must be masked off. Random beats over all four modes and both polarities are mixed with directed clipping cases and a stalled-consumer sequence.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

  typedef enum logic [1:0] {
    RES_NARROW = 2'd0,
    RES_WIDE   = 2'd1,
    RES_MID    = 2'd2,
    RES_FULL   = 2'd3
  } res_mode_e;

  // Result width in bits for a mode/polarity pair.
  function automatic int unsigned res_bits(input logic [1:0] mode,
                                           input logic diff,
                                           input int unsigned full_w);
    case (res_mode_e'(mode))
      RES_NARROW: return diff ? 9  : 8;
      RES_WIDE:   return diff ? 13 : 12;
      RES_MID:    return diff ? 11 : 10;
      default:    return full_w;
    endcase
  endfunction

endpackage

// File: rtl/adc_fmt_extract.sv
module adc_fmt_extract #(
  parameter int DATA_W = 16,
  parameter int CALC_W = DATA_W + 2,
  parameter int NB_W   = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] raw,
  input  logic              diff,
  input  logic [NB_W-1:0]   nbits,
  output logic [CALC_W-1:0] code
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0] top_idx;
  logic             fill;

  assign top_idx = IDX_W'(nbits - NB_W'(1));
  assign fill    = diff & raw[top_idx];

  for (genvar g = 0; g < CALC_W; g++) begin : g_bit
    if (g < DATA_W) begin : g_in
      assign code[g] = (32'(g) < 32'(nbits)) ? raw[g] : fill;
    end else begin : g_ext
      assign code[g] = fill;
    end
  end

endmodule

// File: rtl/adc_fmt_clamp.sv
module adc_fmt_clamp #(
  parameter int DATA_W = 16,
  parameter int CALC_W = DATA_W + 2,
  parameter int NB_W   = $clog2(DATA_W + 1)
) (
  input  logic [CALC_W-1:0] code,
  input  logic [DATA_W-1:0] offset,
  input  logic              diff,
  input  logic [NB_W-1:0]   nbits,
  output logic [CALC_W-1:0] sat
);
  localparam int EXT_W = CALC_W - DATA_W;

  logic signed [CALC_W-1:0] ofs_ext, delta, hi_lim, lo_lim, one, span, half;

  always_comb begin
    ofs_ext = {{EXT_W{offset[DATA_W-1]}}, offset};
    delta   = $signed(code) - ofs_ext;
    one     = CALC_W'(1);
    span    = one << nbits;
    half    = one << (nbits - NB_W'(1));
    hi_lim  = diff ? (half - one) : (span - one);
    lo_lim  = diff ? -half : '0;
    if (delta > hi_lim)      sat = hi_lim;
    else if (delta < lo_lim) sat = lo_lim;
    else                     sat = delta;
  end

endmodule

// File: rtl/adc_fmt_pack.sv
module adc_fmt_pack #(
  parameter int DATA_W = 16,
  parameter int CALC_W = DATA_W + 2,
  parameter int NB_W   = $clog2(DATA_W + 1)
) (
  input  logic [CALC_W-1:0] sat,
  input  logic              diff,
  input  logic [NB_W-1:0]   nbits,
  output logic [DATA_W-1:0] word
);
  localparam int IDX_W = $clog2(CALC_W);

  logic [IDX_W-1:0] sgn_idx;
  logic             pad;

  assign sgn_idx = IDX_W'(nbits - NB_W'(1));
  assign pad     = diff & sat[sgn_idx];

  for (genvar g = 0; g < DATA_W; g++) begin : g_out
    assign word[g] = (32'(g) < 32'(nbits)) ? sat[g] : pad;
  end

endmodule

// File: rtl/adc_result_corrector.sv
module adc_result_corrector
  import adc_fmt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_raw,
  input  logic [1:0]        in_mode,
  input  logic              in_diff,
  input  logic [DATA_W-1:0] in_offset,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int CALC_W = DATA_W + 2;
  localparam int NB_W   = $clog2(DATA_W + 1);

  logic [NB_W-1:0]   nbits;
  logic [CALC_W-1:0] code, sat;
  logic [DATA_W-1:0] word;
  logic              accept;
  logic              vld_q, diff_q;
  logic [NB_W-1:0]   bits_q;
  logic [DATA_W-1:0] data_q;

  assign nbits = NB_W'(res_bits(in_mode, in_diff, DATA_W));

  adc_fmt_extract #(.DATA_W(DATA_W), .CALC_W(CALC_W), .NB_W(NB_W)) u_extract (
    .raw(in_raw), .diff(in_diff), .nbits(nbits), .code(code)
  );

  adc_fmt_clamp #(.DATA_W(DATA_W), .CALC_W(CALC_W), .NB_W(NB_W)) u_clamp (
    .code(code), .offset(in_offset), .diff(in_diff), .nbits(nbits), .sat(sat)
  );

  adc_fmt_pack #(.DATA_W(DATA_W), .CALC_W(CALC_W), .NB_W(NB_W)) u_pack (
    .sat(sat), .diff(in_diff), .nbits(nbits), .word(word)
  );

  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      diff_q <= 1'b0;
      bits_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      vld_q  <= 1'b1;
      diff_q <= in_diff;
      bits_q <= nbits;
      data_q <= word;
    end else if (out_ready) begin
      vld_q  <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;

  // R8
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7
  single_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !diff_q) |-> ((32'(out_data) >> bits_q) == 32'd0));

  // R5
  diff_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && diff_q) |->
      ((int'($signed(out_data)) >= -(32'sd1 <<< (bits_q - 1'b1))) &&
       (int'($signed(out_data)) <= ((32'sd1 <<< (bits_q - 1'b1)) - 32'sd1))));

endmodule

// File: tb/adc_result_corrector_bench.sv
module adc_result_corrector_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_raw = '0;
  logic [1:0]  in_mode = '0;
  logic        in_diff = 1'b0;
  logic [15:0] in_offset = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_result_corrector u_adc_result_corrector (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_raw(in_raw), .in_mode(in_mode), .in_diff(in_diff), .in_offset(in_offset),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [15:0] model(input logic [15:0] raw, input logic [1:0] mode,
                                        input logic d, input logic [15:0] ofs);
    int n, f, v, lo, hi;
    case (mode)
      2'd0: n = d ? 9 : 8;
      2'd1: n = d ? 13 : 12;
      2'd2: n = d ? 11 : 10;
      default: n = 16;
    endcase
    f = int'(raw) & ((1 << n) - 1);
    if (d && f >= (1 << (n - 1))) f = f - (1 << n);
    v = f - int'($signed(ofs));
    hi = d ? (1 << (n - 1)) - 1 : (1 << n) - 1;
    lo = d ? -(1 << (n - 1)) : 0;
    if (v > hi) v = hi;
    if (v < lo) v = lo;
    return v[15:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic beat(input string req, input logic [15:0] raw, input logic [1:0] mode,
                      input logic d, input logic [15:0] ofs);
    @(negedge clk);
    in_raw = raw; in_mode = mode; in_diff = d; in_offset = ofs; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R8 valid"}, 32'(out_valid), 32'd1);
    check(req, 32'(out_data), 32'(model(raw, mode, d, ofs)));
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", 32'(out_valid), 32'd0);
    check("R1 in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", 32'(out_valid), 32'd0);

    beat("R2 mode0 single max", 16'h00FF, 2'd0, 1'b0, 16'h0000);
    check("R2 mode0 single value", 32'(out_data), 32'h00FF);
    beat("R3 upper bits ignored", 16'hFF80, 2'd0, 1'b0, 16'h0000);
    check("R3 masked", 32'(out_data), 32'h0080);
    beat("R6 single floor", 16'h0010, 2'd0, 1'b0, 16'h0020);
    check("R6 floor zero", 32'(out_data), 32'h0000);
    beat("R7 diff sign fill", 16'h01FF, 2'd0, 1'b1, 16'h0000);
    check("R7 minus one", 32'(out_data), 32'hFFFF);
    beat("R5 diff full ceiling", 16'h7FFF, 2'd3, 1'b1, 16'hFFFF);
    check("R5 ceiling", 32'(out_data), 32'h7FFF);
    beat("R6 diff full floor", 16'h8000, 2'd3, 1'b1, 16'h0001);
    check("R6 diff floor", 32'(out_data), 32'h8000);
    beat("R5 single full ceiling", 16'hFFFF, 2'd3, 1'b0, 16'hFFFF);
    check("R5 single ceiling", 32'(out_data), 32'hFFFF);
    beat("R4 mode1 subtract", 16'h0ABC, 2'd1, 1'b0, 16'h0010);
    check("R4 difference", 32'(out_data), 32'h0AAC);
    beat("R2 mode2 diff positive", 16'h03FF, 2'd2, 1'b1, 16'h0000);
    check("R2 mode2 positive", 32'(out_data), 32'h03FF);
    beat("R7 mode2 diff negative", 16'h0400, 2'd2, 1'b1, 16'h0000);
    check("R7 mode2 most negative", 32'(out_data), 32'hFC00);
    beat("R5 mode1 diff ceiling", 16'h0FFF, 2'd1, 1'b1, 16'hF000);
    check("R5 mode1 diff", 32'(out_data), 32'h0FFF);

    for (int i = 0; i < 300; i++) begin
      beat("R4 random", 16'($urandom), 2'($urandom), 1'($urandom), 16'($urandom));
    end

    // R8: output drops when consumer takes it and nothing new arrives
    @(negedge clk);
    check("R8 valid falls", 32'(out_valid), 32'd0);

    // R9 stall sequence
    @(negedge clk);
    out_ready = 1'b0;
    in_raw = 16'h0042; in_mode = 2'd0; in_diff = 1'b0; in_offset = 16'h0002; in_valid = 1'b1;
    @(negedge clk);
    check("R9 first held valid", 32'(out_valid), 32'd1);
    check("R9 first data", 32'(out_data), 32'h0040);
    check("R9 ready low", 32'(in_ready), 32'd0);
    in_raw = 16'h1234; in_mode = 2'd3; in_diff = 1'b0; in_offset = 16'h0004;
    repeat (3) @(negedge clk);
    check("R9 data held", 32'(out_data), 32'h0040);
    check("R9 valid held", 32'(out_valid), 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second data", 32'(out_data), 32'h1230);
    check("R9 second valid", 32'(out_valid), 32'd1);
    @(negedge clk);
    check("R8 drained", 32'(out_valid), 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule